// File: doc/BRIEF.md
# Trap Delegation and Return Controller

This block sits beside the CSR file of a 32-bit core that runs machine (M), supervisor (S) and user (U) privilege. For each instruction boundary the pipeline hands it one request. The request is a normal retirement, a synchronous exception, a pending interrupt, a machine-return or a supervisor-return, and it comes with the cause, the trap value, the current PC and the current privilege. The controller picks the level that takes the trap through a two-stage delegation chain. It also drops interrupts that the current level or the enable bits mask. It then produces the writes to the per-level epc, cause and tval registers, the new status word, the next PC and the new privilege.

The controller does not store CSRs. The CSR file supplies the status, interrupt-enable, delegation, vector base and return address registers as read ports. The controller returns write strobes and data for one cycle. A small state machine orders the work. IDLE accepts a request and moves to DECIDE. DECIDE classifies the request and moves to one of three action states. TAKE commits a trap. RETURN restores state after a return instruction. PASS covers a clean retirement or an ignored interrupt. Each action state lasts one cycle and then goes back to IDLE.

Top module: `trap_ctrl`

## Requirements
- R1: `req_ready` is 1 only in IDLE. A request is taken on a clock edge where `req_ready` and `req_valid` are both high. During the next cycle `req_ready` and `done` are 0. In the cycle after that, `done` is 1 for exactly one cycle with all results valid, and then `req_ready` returns to 1. Request kinds are: 0 retire, 1 exception, 2 interrupt, 3 machine-return, 4 supervisor-return. Privilege codes are: U=0, S=1, M=3.
- R2: The target level is chosen from the machine delegation word and then the supervisor delegation word. Interrupts use the interrupt words and all other traps use the exception words. Both are indexed by the low 5 bits of the cause. A clear machine bit gives M. Otherwise a clear supervisor bit gives S. Otherwise the target is U.
- R3: An interrupt is ignored when its target is below the current level. It is also ignored when its target equals the current level and that level's global enable is clear. The global enables are status bit 3 (M), bit 1 (S) and bit 0 (U). An ignored interrupt gives `done` with no writes, `retire_ok`=0, `next_pc` equal to the request PC and the privilege unchanged.
- R4: An interrupt whose bit in the enable register, at the cause index, is clear is ignored as in R3.
- R5: A taken trap raises `trap_we`. It sets `trap_level` and `new_priv` to the target, `epc_wdata` to the request PC, and `cause_wdata` and `tval_wdata` to the effective cause and trap value.
- R6: The trap vector base is chosen by target level. When its low two bits are 0, `next_pc` is the base unchanged. Otherwise `next_pc` is the base with the low two bits cleared, plus 4 times the cause index.
- R7: A trap to M writes status with bit 7 set to the old bit 3, bits 12:11 set to the previous privilege, and bit 3 cleared.
- R8: A trap to S writes status with bit 5 set to the old bit 1, bit 8 set to bit 0 of the previous privilege, and bit 1 cleared. A trap to U does not write status.
- R9: A machine-return issued in M sets `next_pc` to the machine epc and `new_priv` to status bits 12:11. It writes status with bit 3 set to the old bit 7, bit 7 set to 1, and bits 12:11 cleared.
- R10: A supervisor-return issued in S or M sets `next_pc` to the supervisor epc and `new_priv` to status bit 8 (U or S). It writes status with bit 1 set to the old bit 5, bit 5 set to 1, and bit 8 cleared.
- R11: A machine-return issued below M, or a supervisor-return issued in U, is turned into an exception with cause 2 and the request PC as trap value. That exception is routed as in R2.
- R12: A retirement with an aligned PC gives `retire_ok`=1, `next_pc`=PC+4 and no writes. A retirement whose PC has a nonzero low two bits is turned into an exception with cause 0 and the PC as trap value, and `retire_ok` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Request kind (R1 encoding) |
| req_cause | input | 32 | Cause code, bit 31 set for interrupts |
| req_tval | input | 32 | Trap value for exceptions |
| req_pc | input | 32 | PC of the instruction boundary |
| cur_priv | input | 2 | Current privilege |
| csr_status | input | 32 | Status register read port |
| csr_ie | input | 32 | Interrupt-enable register read port |
| csr_m_edeleg | input | 32 | Machine exception delegation |
| csr_m_ideleg | input | 32 | Machine interrupt delegation |
| csr_s_edeleg | input | 32 | Supervisor exception delegation |
| csr_s_ideleg | input | 32 | Supervisor interrupt delegation |
| csr_m_tvec | input | 32 | Machine trap vector base |
| csr_s_tvec | input | 32 | Supervisor trap vector base |
| csr_u_tvec | input | 32 | User trap vector base |
| csr_m_epc | input | 32 | Machine return address |
| csr_s_epc | input | 32 | Supervisor return address |
| req_ready | output | 1 | Controller idle |
| done | output | 1 | Results valid this cycle |
| retire_ok | output | 1 | Instruction may commit its register and CSR writes |
| next_pc | output | 32 | Next PC |
| new_priv | output | 2 | Privilege after this request |
| trap_we | output | 1 | Write epc/cause/tval of `trap_level` |
| trap_level | output | 2 | Level whose trap registers are written |
| epc_wdata | output | 32 | epc write data |
| cause_wdata | output | 32 | cause write data |
| tval_wdata | output | 32 | tval write data |
| status_we | output | 1 | Status write strobe |
| status_wdata | output | 32 | Status write data |

## Verification
The assertions assume that `cur_priv` and every CSR read port stay stable from acceptance until `done`. They also assume that machine status bits 12:11 never hold the reserved code 2. The stimulus sets all CSR values at a falling edge before each request and leaves them alone until the controller is idle again. It uses only legal privilege codes. Each request gets an expected result from a behavioural model in the bench. The bench then compares the handshake and the outputs on every cycle of the request's life.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        REQ_RETIRE = 3'd0,
        REQ_EXC    = 3'd1,
        REQ_IRQ    = 3'd2,
        REQ_MRET   = 3'd3,
        REQ_SRET   = 3'd4
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_TAKE,
        ST_RETURN,
        ST_PASS
    } state_e;

    typedef enum logic [1:0] {
        OP_TRAP_M,
        OP_TRAP_S,
        OP_MRET,
        OP_SRET
    } stack_op_e;

    localparam int B_UIE  = 0;
    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPP  = 11;

    localparam logic [31:0] CAUSE_MISALIGNED_FETCH = 32'd0;
    localparam logic [31:0] CAUSE_ILLEGAL          = 32'd2;

endpackage

// File: rtl/trap_route.sv
module trap_route #(
    parameter int XLEN = 32,
    parameter int IDXW = $clog2(XLEN)
) (
    input  logic            is_irq,
    input  logic [IDXW-1:0] cause_idx,
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] m_edeleg,
    input  logic [XLEN-1:0] m_ideleg,
    input  logic [XLEN-1:0] s_edeleg,
    input  logic [XLEN-1:0] s_ideleg,
    input  logic [3:0]      global_en,
    input  logic [XLEN-1:0] ie_mask,
    output logic [1:0]      target,
    output logic            irq_blocked
);
    logic [XLEN-1:0] m_word, s_word;
    logic            level_en;

    always_comb begin
        m_word = is_irq ? m_ideleg : m_edeleg;
        s_word = is_irq ? s_ideleg : s_edeleg;
        if (!m_word[cause_idx])      target = 2'd3;
        else if (!s_word[cause_idx]) target = 2'd1;
        else                         target = 2'd0;
        // global enable bits sit at the position equal to the privilege code
        level_en    = global_en[cur_priv];
        irq_blocked = is_irq && ((target < cur_priv) ||
                                 ((target == cur_priv) && !level_en) ||
                                 !ie_mask[cause_idx]);
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int XLEN      = 32,
    parameter int IDXW      = $clog2(XLEN),
    parameter bit VECTOR_EN = 1'b1
) (
    input  logic [XLEN-1:0] tvec,
    input  logic [IDXW-1:0] cause_idx,
    output logic [XLEN-1:0] target_pc
);
    generate
        if (VECTOR_EN) begin : g_vectored
            logic [XLEN-1:0] base, offset;
            always_comb begin
                base      = {tvec[XLEN-1:2], 2'b00};
                offset    = XLEN'(cause_idx) << 2;
                target_pc = (tvec[1:0] != 2'b00) ? base + offset : tvec;
            end
        end else begin : g_direct
            assign target_pc = {tvec[XLEN-1:2], 2'b00};
        end
    endgenerate
endmodule

// File: rtl/status_stack.sv
module status_stack
    import trap_ctrl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  stack_op_e       op,
    input  logic [XLEN-1:0] status,
    input  logic [1:0]      prev_priv,
    output logic [XLEN-1:0] status_out,
    output logic [1:0]      ret_priv
);
    always_comb begin
        status_out = status;
        ret_priv   = prev_priv;
        unique case (op)
            OP_TRAP_M: begin
                status_out[B_MPIE]        = status[B_MIE];
                status_out[B_MPP+1:B_MPP] = prev_priv;
                status_out[B_MIE]         = 1'b0;
            end
            OP_TRAP_S: begin
                status_out[B_SPIE] = status[B_SIE];
                status_out[B_SPP]  = prev_priv[0];
                status_out[B_SIE]  = 1'b0;
            end
            OP_MRET: begin
                ret_priv                  = status[B_MPP+1:B_MPP];
                status_out[B_MIE]         = status[B_MPIE];
                status_out[B_MPIE]        = 1'b1;
                status_out[B_MPP+1:B_MPP] = 2'd0;
            end
            OP_SRET: begin
                ret_priv           = {1'b0, status[B_SPP]};
                status_out[B_SIE]  = status[B_SPIE];
                status_out[B_SPIE] = 1'b1;
                status_out[B_SPP]  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_ctrl_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit VECTOR_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_kind,
    input  logic [XLEN-1:0] req_cause,
    input  logic [XLEN-1:0] req_tval,
    input  logic [XLEN-1:0] req_pc,
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] csr_status,
    input  logic [XLEN-1:0] csr_ie,
    input  logic [XLEN-1:0] csr_m_edeleg,
    input  logic [XLEN-1:0] csr_m_ideleg,
    input  logic [XLEN-1:0] csr_s_edeleg,
    input  logic [XLEN-1:0] csr_s_ideleg,
    input  logic [XLEN-1:0] csr_m_tvec,
    input  logic [XLEN-1:0] csr_s_tvec,
    input  logic [XLEN-1:0] csr_u_tvec,
    input  logic [XLEN-1:0] csr_m_epc,
    input  logic [XLEN-1:0] csr_s_epc,
    output logic            req_ready,
    output logic            done,
    output logic            retire_ok,
    output logic [XLEN-1:0] next_pc,
    output logic [1:0]      new_priv,
    output logic            trap_we,
    output logic [1:0]      trap_level,
    output logic [XLEN-1:0] epc_wdata,
    output logic [XLEN-1:0] cause_wdata,
    output logic [XLEN-1:0] tval_wdata,
    output logic            status_we,
    output logic [XLEN-1:0] status_wdata
);
    localparam int IDXW = $clog2(XLEN);

    state_e          state_q, state_d;
    logic [2:0]      r_kind;
    logic [XLEN-1:0] r_cause, r_tval, r_pc;
    logic [1:0]      r_cur, r_target;
    logic            r_irq;

    logic            d_take, d_ret, d_irq;
    logic [XLEN-1:0] d_cause, d_tval;
    logic [1:0]      route_target;
    logic            route_blocked;
    logic [XLEN-1:0] tvec_sel, vec_pc;
    stack_op_e       op;
    logic [XLEN-1:0] stacked;
    logic [1:0]      ret_priv;

    // classify the latched request
    always_comb begin
        d_take  = 1'b0;
        d_ret   = 1'b0;
        d_irq   = 1'b0;
        d_cause = r_cause;
        d_tval  = r_tval;
        unique case (req_kind_e'(r_kind))
            REQ_RETIRE: if (r_pc[1:0] != 2'b00) begin
                d_take  = 1'b1;
                d_cause = CAUSE_MISALIGNED_FETCH;
                d_tval  = r_pc;
            end
            REQ_EXC:  d_take = 1'b1;
            REQ_IRQ: begin
                d_take = 1'b1;
                d_irq  = 1'b1;
            end
            REQ_MRET: if (r_cur == PRIV_M) d_ret = 1'b1;
                      else begin
                          d_take  = 1'b1;
                          d_cause = CAUSE_ILLEGAL;
                          d_tval  = r_pc;
                      end
            REQ_SRET: if (r_cur != PRIV_U) d_ret = 1'b1;
                      else begin
                          d_take  = 1'b1;
                          d_cause = CAUSE_ILLEGAL;
                          d_tval  = r_pc;
                      end
            default: begin
                d_take  = 1'b1;
                d_cause = CAUSE_ILLEGAL;
                d_tval  = r_pc;
            end
        endcase
    end

    trap_route #(.XLEN(XLEN), .IDXW(IDXW)) u_route (
        .is_irq     (d_irq),
        .cause_idx  (d_cause[IDXW-1:0]),
        .cur_priv   (r_cur),
        .m_edeleg   (csr_m_edeleg),
        .m_ideleg   (csr_m_ideleg),
        .s_edeleg   (csr_s_edeleg),
        .s_ideleg   (csr_s_ideleg),
        .global_en  (csr_status[3:0]),
        .ie_mask    (csr_ie),
        .target     (route_target),
        .irq_blocked(route_blocked)
    );

    always_comb begin
        unique case (r_target)
            PRIV_M:  tvec_sel = csr_m_tvec;
            PRIV_S:  tvec_sel = csr_s_tvec;
            default: tvec_sel = csr_u_tvec;
        endcase
    end

    trap_vector #(.XLEN(XLEN), .IDXW(IDXW), .VECTOR_EN(VECTOR_EN)) u_vec (
        .tvec     (tvec_sel),
        .cause_idx(r_cause[IDXW-1:0]),
        .target_pc(vec_pc)
    );

    always_comb begin
        if (state_q == ST_TAKE) op = (r_target == PRIV_M) ? OP_TRAP_M : OP_TRAP_S;
        else                    op = (r_kind == REQ_MRET) ? OP_MRET : OP_SRET;
    end

    status_stack #(.XLEN(XLEN)) u_stack (
        .op        (op),
        .status    (csr_status),
        .prev_priv (r_cur),
        .status_out(stacked),
        .ret_priv  (ret_priv)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (d_ret)                         state_d = ST_RETURN;
                else if (d_take && !route_blocked) state_d = ST_TAKE;
                else                               state_d = ST_PASS;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_kind   <= '0;
            r_cause  <= '0;
            r_tval   <= '0;
            r_pc     <= '0;
            r_cur    <= '0;
            r_irq    <= 1'b0;
            r_target <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            r_kind  <= req_kind;
            r_cause <= req_cause;
            r_tval  <= req_tval;
            r_pc    <= req_pc;
            r_cur   <= cur_priv;
        end else if (state_q == ST_DECIDE) begin
            r_cause  <= d_cause;
            r_tval   <= d_tval;
            r_irq    <= d_irq;
            r_target <= route_target;
        end
    end

    // output logic
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        done         = 1'b0;
        retire_ok    = 1'b0;
        next_pc      = r_pc;
        new_priv     = r_cur;
        trap_we      = 1'b0;
        trap_level   = r_target;
        epc_wdata    = r_pc;
        cause_wdata  = r_cause;
        tval_wdata   = r_tval;
        status_we    = 1'b0;
        status_wdata = stacked;
        unique case (state_q)
            ST_TAKE: begin
                done      = 1'b1;
                trap_we   = 1'b1;
                next_pc   = vec_pc;
                new_priv  = r_target;
                status_we = (r_target != PRIV_U);
            end
            ST_RETURN: begin
                done      = 1'b1;
                status_we = 1'b1;
                next_pc   = (r_kind == REQ_MRET) ? csr_m_epc : csr_s_epc;
                new_priv  = ret_priv;
            end
            ST_PASS: begin
                done      = 1'b1;
                retire_ok = !r_irq;
                next_pc   = r_irq ? r_pc : r_pc + XLEN'(4);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_ctrl_checks.sv
module trap_ctrl_checks #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            done,
    input logic            retire_ok,
    input logic [XLEN-1:0] next_pc,
    input logic [1:0]      new_priv,
    input logic            trap_we,
    input logic [1:0]      trap_level,
    input logic            status_we,
    input logic [XLEN-1:0] status_wdata
);
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (!req_ready && !done) ##1 done);

    assert_idle_not_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !done);

    assert_strobes_in_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_we || status_we || retire_ok) |-> done);

    assert_level_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_we |-> (trap_level != 2'd2 && new_priv == trap_level));

    assert_mtrap_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_we && trap_level == 2'd3) |-> (status_we && !status_wdata[3]));

    assert_strap_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_we && trap_level == 2'd1) |-> (status_we && !status_wdata[1]));

    assert_utrap_nostatus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_we && trap_level == 2'd0) |-> !status_we);

    // R9 and R10: a return leaves the previous-mode field at U and its pending-enable at 1
    assert_return_restack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_we && !trap_we) |->
            ((status_wdata[12:11] == 2'd0 && status_wdata[7]) ||
             (!status_wdata[8] && status_wdata[5])));

    assert_retire_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        retire_ok |-> (!trap_we && !status_we && next_pc[1:0] == 2'b00));
endmodule

bind trap_ctrl trap_ctrl_checks #(.XLEN(XLEN)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .done        (done),
    .retire_ok   (retire_ok),
    .next_pc     (next_pc),
    .new_priv    (new_priv),
    .trap_we     (trap_we),
    .trap_level  (trap_level),
    .status_we   (status_we),
    .status_wdata(status_wdata)
);

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [31:0] req_cause = '0, req_tval = '0, req_pc = '0;
    logic [1:0]  cur_priv = 2'd3;
    logic [31:0] csr_status = '0, csr_ie = '0;
    logic [31:0] csr_m_edeleg = '0, csr_m_ideleg = '0, csr_s_edeleg = '0, csr_s_ideleg = '0;
    logic [31:0] csr_m_tvec = '0, csr_s_tvec = '0, csr_u_tvec = '0, csr_m_epc = '0, csr_s_epc = '0;
    logic        req_ready, done, retire_ok, trap_we, status_we;
    logic [31:0] next_pc, epc_wdata, cause_wdata, tval_wdata, status_wdata;
    logic [1:0]  new_priv, trap_level;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // expected results
    logic        e_trap_we, e_swe, e_ok;
    logic [1:0]  e_level, e_priv;
    logic [31:0] e_next, e_epc, e_cause, e_tval, e_sdata;

    always #4 clk = ~clk;

    trap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_cause(req_cause), .req_tval(req_tval), .req_pc(req_pc), .cur_priv(cur_priv),
        .csr_status(csr_status), .csr_ie(csr_ie),
        .csr_m_edeleg(csr_m_edeleg), .csr_m_ideleg(csr_m_ideleg),
        .csr_s_edeleg(csr_s_edeleg), .csr_s_ideleg(csr_s_ideleg),
        .csr_m_tvec(csr_m_tvec), .csr_s_tvec(csr_s_tvec), .csr_u_tvec(csr_u_tvec),
        .csr_m_epc(csr_m_epc), .csr_s_epc(csr_s_epc),
        .req_ready(req_ready), .done(done), .retire_ok(retire_ok), .next_pc(next_pc),
        .new_priv(new_priv), .trap_we(trap_we), .trap_level(trap_level),
        .epc_wdata(epc_wdata), .cause_wdata(cause_wdata), .tval_wdata(tval_wdata),
        .status_we(status_we), .status_wdata(status_wdata)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference for one request
    task automatic predict(input int kind, input logic [31:0] cause, input logic [31:0] tval,
                           input logic [31:0] pc, input logic [1:0] cur);
        bit take, ret, irq, glb;
        int idx;
        logic [31:0] c, v, mw, sw, s, tv;
        logic [1:0] tgt;
        take = 0; ret = 0; irq = 0; c = cause; v = tval; s = csr_status;
        e_trap_we = 0; e_swe = 0; e_ok = 0; e_next = pc; e_priv = cur;
        e_level = 0; e_epc = 0; e_cause = 0; e_tval = 0; e_sdata = 0;
        if (kind == 0) begin
            if (pc % 4 != 0) begin take = 1; c = 0; v = pc; end
            else begin e_ok = 1; e_next = pc + 4; end
        end else if (kind == 1) take = 1;
        else if (kind == 2) begin take = 1; irq = 1; end
        else if (kind == 3) begin
            if (cur == 3) ret = 1; else begin take = 1; c = 2; v = pc; end
        end else begin
            if (cur != 0) ret = 1; else begin take = 1; c = 2; v = pc; end
        end
        if (take) begin
            idx = int'(c % 32);
            mw = irq ? csr_m_ideleg : csr_m_edeleg;
            sw = irq ? csr_s_ideleg : csr_s_edeleg;
            if (mw[idx] == 0) tgt = 3; else if (sw[idx] == 0) tgt = 1; else tgt = 0;
            glb = (cur == 3) ? s[3] : (cur == 1) ? s[1] : s[0];
            if (!(irq && (tgt < cur || (tgt == cur && !glb) || !csr_ie[idx]))) begin
                e_trap_we = 1; e_level = tgt; e_priv = tgt;
                e_epc = pc; e_cause = c; e_tval = v;
                tv = (tgt == 3) ? csr_m_tvec : (tgt == 1) ? csr_s_tvec : csr_u_tvec;
                if (tv % 4 != 0) e_next = (tv - (tv % 4)) + 32'(4 * idx);
                else             e_next = tv;
                if (tgt == 3) begin
                    s[7] = s[3]; s[12:11] = cur; s[3] = 0; e_swe = 1;
                end else if (tgt == 1) begin
                    s[5] = s[1]; s[8] = cur[0]; s[1] = 0; e_swe = 1;
                end
                e_sdata = s;
            end
        end
        if (ret && kind == 3) begin
            e_next = csr_m_epc; e_priv = s[12:11];
            s[3] = s[7]; s[7] = 1; s[12:11] = 0; e_swe = 1; e_sdata = s;
        end else if (ret) begin
            e_next = csr_s_epc; e_priv = {1'b0, s[8]};
            s[1] = s[5]; s[5] = 1; s[8] = 0; e_swe = 1; e_sdata = s;
        end
    endtask

    task automatic run(input string req, input int kind, input logic [31:0] cause,
                       input logic [31:0] tval, input logic [31:0] pc, input logic [1:0] cur);
        predict(kind, cause, tval, pc, cur);
        @(negedge clk);
        req_kind = 3'(kind); req_cause = cause; req_tval = tval; req_pc = pc;
        cur_priv = cur; req_valid = 1'b1;
        chk("R1", "ready before accept", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "ready while deciding", 32'(req_ready), 32'd0);
        chk("R1", "done while deciding", 32'(done), 32'd0);
        @(negedge clk);
        chk("R1", "done pulse", 32'(done), 32'd1);
        chk(req, "trap_we", 32'(trap_we), 32'(e_trap_we));
        chk(req, "status_we", 32'(status_we), 32'(e_swe));
        chk(req, "retire_ok", 32'(retire_ok), 32'(e_ok));
        chk(req, "next_pc", next_pc, e_next);
        chk(req, "new_priv", 32'(new_priv), 32'(e_priv));
        if (e_trap_we) begin
            chk(req, "trap_level", 32'(trap_level), 32'(e_level));
            chk(req, "epc", epc_wdata, e_epc);
            chk(req, "cause", cause_wdata, e_cause);
            chk(req, "tval", tval_wdata, e_tval);
        end
        if (e_swe) chk(req, "status_wdata", status_wdata, e_sdata);
        @(negedge clk);
        chk("R1", "ready after done", 32'(req_ready), 32'd1);
        chk("R1", "done after pulse", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset ready", 32'(req_ready), 32'd1);
        chk("R1", "reset done", 32'(done), 32'd0);
        chk("R5", "reset trap_we", 32'(trap_we), 32'd0);
        rst_n = 1'b1;

        csr_m_tvec = 32'h8000_0000; csr_s_tvec = 32'h4000_0000; csr_u_tvec = 32'h2000_0000;
        csr_m_epc = 32'h0000_3000; csr_s_epc = 32'h0000_5000;

        // R12 aligned retirement and misaligned fetch
        csr_status = 32'h0000_0008;
        run("R12", 0, 0, 0, 32'h0000_0100, 2'd3);
        // R7 misaligned fetch traps to M from S
        run("R7", 0, 0, 0, 32'h0000_0102, 2'd1);

        // R2 illegal from U delegated once -> S, R8 stacking
        csr_status = 32'h0000_0003; csr_m_edeleg = 32'h0000_0104; csr_s_edeleg = 32'h0000_0100;
        run("R2", 1, 32'd2, 32'hDEAD_BEEF, 32'h0000_0200, 2'd0);
        run("R8", 1, 32'd2, 32'h1234_5678, 32'h0000_0204, 2'd1);
        // R8 ecall from U delegated twice -> U, no status write
        run("R8", 1, 32'd8, 32'h0, 32'h0000_0300, 2'd0);
        // R5 undelegated store fault goes to M
        run("R5", 1, 32'd7, 32'hCAFE_0000, 32'h0000_0310, 2'd1);

        // R6 vectored machine timer interrupt from S
        csr_m_edeleg = 0; csr_s_edeleg = 0;
        csr_m_tvec = 32'h8000_0001; csr_ie = 32'h0000_0AAA;
        run("R6", 2, 32'h8000_0007, 32'h0, 32'h0000_0400, 2'd1);
        // R4 same interrupt with its enable bit clear
        csr_ie = 32'h0000_0A2A;
        run("R4", 2, 32'h8000_0007, 32'h0, 32'h0000_0404, 2'd1);
        // R3 supervisor timer delegated to S while in M: ignored
        csr_ie = 32'h0000_0AAA; csr_m_ideleg = 32'h0000_0222;
        run("R3", 2, 32'h8000_0005, 32'h0, 32'h0000_0408, 2'd3);
        // R3 M-level interrupt in M, MIE clear then set
        csr_status = 32'h0000_0000;
        run("R3", 2, 32'h8000_000B, 32'h0, 32'h0000_0410, 2'd3);
        csr_status = 32'h0000_0008;
        run("R3", 2, 32'h8000_000B, 32'h0, 32'h0000_0414, 2'd3);
        // R3 delegated S external interrupt, in S with SIE set, vectored S base
        csr_status = 32'h0000_0002; csr_s_tvec = 32'h4000_0003;
        run("R3", 2, 32'h8000_0009, 32'h0, 32'h0000_0418, 2'd1);
        // R6 vectored S base for an exception
        csr_m_edeleg = 32'h0000_0004;
        run("R6", 1, 32'd2, 32'h0, 32'h0000_041C, 2'd0);
        csr_m_edeleg = 0;

        // R9 machine-return to S
        csr_status = 32'h0000_0880;
        run("R9", 3, 0, 0, 32'h0000_0500, 2'd3);
        // R10 supervisor-return to U with SPIE clear
        csr_status = 32'h0000_0002;
        run("R10", 4, 0, 0, 32'h0000_0504, 2'd1);
        // R10 supervisor-return to S from M
        csr_status = 32'h0000_0120;
        run("R10", 4, 0, 0, 32'h0000_0508, 2'd3);
        // R11 machine-return from S and supervisor-return from U
        csr_status = 32'h0000_0002;
        run("R11", 3, 0, 0, 32'h0000_0600, 2'd1);
        run("R11", 4, 0, 0, 32'h0000_0604, 2'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule